// File: doc/BRIEF.md
# Flash Command State Machine

This block sits between a bus that issues write cycles and an array model that performs the slow program and erase work. It turns single writes and two-write sequences into array commands: program a word, erase a sector, erase a plane, erase the whole array, suspend and resume. It also checks each request against a per-sector lock map before anything is started. Alongside the command path it keeps an 8-bit status word whose error flags stay set until software clears them, and it selects what a read returns: array data, the status word or identification codes.

Reads share the array with a running operation. The block therefore tells the read path whether an array read at a given address is safe. A plane busy with a program or erase cannot be read. A suspended erase fences off its own sector, plane or whole array. A suspended program fences off only its own word.

Every write on the command port is accepted in the cycle it is presented, so there is no back-pressure. Commands are decoded from the low byte of the data bus. The upper byte is used only as program data.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the status word is 80h, the read select is array (0), no array command is issued and array reads are allowed. Reset also abandons any operation in progress.
- R2: Writing FFh, 70h or 90h sets the read select to array (0), status (1) or identification (2). In status mode `ctl_rdata` carries the status word in its low byte. In identification mode it carries the maker code at plane offset 0, the device code at offset 1 and zero at every other offset.
- R3: Writing 40h or 10h, followed by a write of data, issues a program command (code 1) carrying that write's address and full data word. Status bit 7 (ready) stays low until the array signals done.
- R4: Writing 20h, followed by a confirm write of 20h, 22h or 21h, issues a sector, plane or chip erase (codes 2, 3, 4). The address sent is the confirm write's address.
- R5: Any other confirm after 20h issues nothing. It sets the sequence error bit (3) and the erase error bit (5).
- R6: B0h suspends a running program or erase (code 5), and D0h resumes it (code 6). While suspended, ready is high and exactly one of bit 6 (erase) or bit 2 (program) is set.
- R7: During an erase suspend, a program outside the suspended erase region is started, and ready goes low while bit 6 stays high. A program inside that region issues nothing and sets bit 4 (program error).
- R8: `rd_allow` is low for an array read that falls in a plane with an active operation, in any plane during a chip erase, in the region of a suspended erase, or at the word of a suspended program. It is high otherwise.
- R9: A program to a locked sector, or an erase whose scope contains any locked sector, issues nothing and sets bit 1 (lock error).
- R10: Bits 1, 3, 4 and 5 are sticky, and only a write of 50h clears them. A done with a fail indication sets bit 5 for an erase and bit 4 for a program.
- R11: An erase confirm while bit 1 or bit 3 is set issues nothing.
- R12: An undefined code, or a command that is not valid in the current state, changes nothing, including the read select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One bus write cycle this clock |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Write data; low byte is the command code |
| lock_map | input | NSECT | One lock bit per sector |
| arr_done | input | 1 | Array finished the active operation |
| arr_fail | input | 1 | Qualifies arr_done as a failure |
| rd_addr | input | AW | Address of the current read |
| arr_valid | output | 1 | One-cycle array command strobe |
| arr_cmd | output | 3 | Array command code |
| arr_addr | output | AW | Address for the array command |
| arr_data | output | DW | Program data |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 identification |
| status | output | 8 | Status word |
| rd_allow | output | 1 | Array read at rd_addr is safe |
| ctl_rdata | output | DW | Status or identification read data |

## Verification
The hardest state to reach from the ports is a program running inside a suspended erase, because it is three levels deep: an erase must be started, then suspended, and then a program must be set up and started. The table walks that path twice. The first pass aims the program inside the erase's sector, so that the abort and the sticky program error can be seen. The second pass aims the program outside it, so that the nested done returns the machine to erase suspend rather than to idle. Directed steps then hold reads at chosen addresses during running and suspended operations to probe each fence of the read gate.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CODE_PROG_A  = 8'h40;
  localparam logic [7:0] CODE_PROG_B  = 8'h10;
  localparam logic [7:0] CODE_ERASE   = 8'h20;
  localparam logic [7:0] CODE_CF_SECT = 8'h20;
  localparam logic [7:0] CODE_CF_PLN  = 8'h22;
  localparam logic [7:0] CODE_CF_CHIP = 8'h21;
  localparam logic [7:0] CODE_SUSP    = 8'hB0;
  localparam logic [7:0] CODE_RES     = 8'hD0;
  localparam logic [7:0] CODE_RSTAT   = 8'h70;
  localparam logic [7:0] CODE_RARR    = 8'hFF;
  localparam logic [7:0] CODE_RID     = 8'h90;
  localparam logic [7:0] CODE_CLR     = 8'h50;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PSETUP, ST_ESETUP, ST_PRUN, ST_ERUN,
    ST_PSUSP, ST_ESUSP, ST_EPSETUP, ST_EPRUN
  } fsm_t;

  typedef enum logic [2:0] {
    AC_NONE = 3'd0, AC_PROG = 3'd1, AC_ERS_SECT = 3'd2, AC_ERS_PLANE = 3'd3,
    AC_ERS_CHIP = 3'd4, AC_SUSP = 3'd5, AC_RES = 3'd6
  } acmd_t;

  typedef enum logic [1:0] {RS_ARRAY = 2'd0, RS_STATUS = 2'd1, RS_IDENT = 2'd2} rsel_t;

  typedef enum logic [1:0] {ES_SECT = 2'd0, ES_PLANE = 2'd1, ES_CHIP = 2'd2} escope_t;

  typedef enum logic [3:0] {
    OP_NONE, OP_PROG, OP_ERASE, OP_SUSP, OP_RES, OP_RSTAT, OP_RARR, OP_RID, OP_CLR
  } op_t;

  // region activity seen by the read gate
  typedef enum logic [1:0] {RG_NONE = 2'd0, RG_ACTIVE = 2'd1, RG_HELD = 2'd2} rgmode_t;

endpackage

// File: rtl/fcsm_decode.sv
module fcsm_decode
  import flash_cmd_pkg::*;
(
  input  logic [7:0] code,
  output op_t        op,
  output logic       cf_ok,
  output escope_t    cf_scope
);

  always_comb begin
    unique case (code)
      CODE_PROG_A, CODE_PROG_B: op = OP_PROG;
      CODE_ERASE:               op = OP_ERASE;
      CODE_SUSP:                op = OP_SUSP;
      CODE_RES:                 op = OP_RES;
      CODE_RSTAT:               op = OP_RSTAT;
      CODE_RARR:                op = OP_RARR;
      CODE_RID:                 op = OP_RID;
      CODE_CLR:                 op = OP_CLR;
      default:                  op = OP_NONE;
    endcase
  end

  always_comb begin
    cf_ok    = 1'b1;
    cf_scope = ES_SECT;
    unique case (code)
      CODE_CF_SECT: cf_scope = ES_SECT;
      CODE_CF_PLN:  cf_scope = ES_PLANE;
      CODE_CF_CHIP: cf_scope = ES_CHIP;
      default:      cf_ok    = 1'b0;
    endcase
  end

endmodule

// File: rtl/fcsm_status.sv
module fcsm_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_lock,
  input  logic       set_seq,
  input  logic       set_perr,
  input  logic       set_eerr,
  input  logic       clr,
  input  logic       busy,
  input  logic       esusp,
  input  logic       psusp,
  output logic [7:0] status,
  output logic       err_block
);

  logic lock_q, seq_q, perr_q, eerr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      seq_q  <= 1'b0;
      perr_q <= 1'b0;
      eerr_q <= 1'b0;
    end else begin
      lock_q <= set_lock | (lock_q & ~clr);
      seq_q  <= set_seq  | (seq_q  & ~clr);
      perr_q <= set_perr | (perr_q & ~clr);
      eerr_q <= set_eerr | (eerr_q & ~clr);
    end
  end

  assign status    = {~busy, esusp, eerr_q, perr_q, seq_q, psusp, lock_q, 1'b0};
  assign err_block = lock_q | seq_q;

endmodule

// File: rtl/fcsm_readgate.sv
module fcsm_readgate
  import flash_cmd_pkg::*;
#(
  parameter int AW  = 10,
  parameter int SW  = 6,
  parameter int PW  = 2,
  parameter int DW  = 16,
  parameter logic [DW-1:0] MAKER_ID  = 16'h00C3,
  parameter logic [DW-1:0] DEVICE_ID = 16'h00E4
) (
  input  logic [1:0]    rd_sel,
  input  logic [AW-1:0] rd_addr,
  input  logic [7:0]    status,
  input  rgmode_t       ers_mode,
  input  escope_t       ers_scope,
  input  logic [AW-1:0] ers_addr,
  input  rgmode_t       prg_mode,
  input  logic [AW-1:0] prg_addr,
  output logic          rd_allow,
  output logic [DW-1:0] ctl_rdata
);

  localparam int OFFW = AW - PW;

  logic same_plane_e, same_sect_e, same_plane_p, ers_block, prg_block;
  logic [OFFW-1:0] offs;

  assign same_plane_e = rd_addr[AW-1:AW-PW] == ers_addr[AW-1:AW-PW];
  assign same_sect_e  = rd_addr[AW-1:SW]    == ers_addr[AW-1:SW];
  assign same_plane_p = rd_addr[AW-1:AW-PW] == prg_addr[AW-1:AW-PW];
  assign offs         = rd_addr[OFFW-1:0];

  always_comb begin
    ers_block = 1'b0;
    unique case (ers_mode)
      RG_ACTIVE: ers_block = (ers_scope == ES_CHIP) | same_plane_e;
      RG_HELD: begin
        unique case (ers_scope)
          ES_SECT:  ers_block = same_sect_e;
          ES_PLANE: ers_block = same_plane_e;
          default:  ers_block = 1'b1;
        endcase
      end
      default: ers_block = 1'b0;
    endcase
  end

  always_comb begin
    unique case (prg_mode)
      RG_ACTIVE: prg_block = same_plane_p;
      RG_HELD:   prg_block = rd_addr == prg_addr;
      default:   prg_block = 1'b0;
    endcase
  end

  assign rd_allow = (rd_sel != RS_ARRAY) | ~(ers_block | prg_block);

  always_comb begin
    ctl_rdata = '0;
    if (rd_sel == RS_STATUS) begin
      ctl_rdata[7:0] = status;
    end else if (rd_sel == RS_IDENT) begin
      if (offs == OFFW'(0))      ctl_rdata = MAKER_ID;
      else if (offs == OFFW'(1)) ctl_rdata = DEVICE_ID;
    end
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 10,
  parameter int SW = 6,
  parameter int PW = 2,
  parameter int DW = 16,
  parameter logic [DW-1:0] MAKER_ID  = 16'h00C3,
  parameter logic [DW-1:0] DEVICE_ID = 16'h00E4,
  localparam int SI    = AW - SW,
  localparam int NSECT = 1 << SI
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [NSECT-1:0] lock_map,
  input  logic             arr_done,
  input  logic             arr_fail,
  input  logic [AW-1:0]    rd_addr,
  output logic             arr_valid,
  output logic [2:0]       arr_cmd,
  output logic [AW-1:0]    arr_addr,
  output logic [DW-1:0]    arr_data,
  output logic [1:0]       rd_sel,
  output logic [7:0]       status,
  output logic             rd_allow,
  output logic [DW-1:0]    ctl_rdata
);

  fsm_t    st, st_n;
  rsel_t   sel_q, sel_n;
  escope_t ers_scope_q;
  logic [AW-1:0] ers_addr_q, prg_addr_q;

  op_t     op;
  logic    cf_ok;
  escope_t cf_scope;

  logic    iss, ecap, pcap;
  acmd_t   icmd;
  logic    set_lock, set_seq, set_perr, set_eerr, clr, err_block;
  logic    running, esusp, psusp;
  rgmode_t ers_mode, prg_mode;

  fcsm_decode u_dec (
    .code     (wr_data[7:0]),
    .op       (op),
    .cf_ok    (cf_ok),
    .cf_scope (cf_scope)
  );

  // true when any locked sector lies inside the given erase scope
  function automatic logic scope_locked(escope_t sc, logic [AW-1:0] a, logic [NSECT-1:0] map);
    logic r;
    logic [SI-1:0] idx;
    r = 1'b0;
    for (int i = 0; i < NSECT; i++) begin
      idx = SI'(i);
      if (map[i]) begin
        if (sc == ES_CHIP) r = 1'b1;
        else if (sc == ES_PLANE && idx[SI-1:SI-PW] == a[AW-1:AW-PW]) r = 1'b1;
        else if (sc == ES_SECT && idx == a[AW-1:SW]) r = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic in_held_erase(logic [AW-1:0] a);
    logic r;
    unique case (ers_scope_q)
      ES_SECT:  r = a[AW-1:SW] == ers_addr_q[AW-1:SW];
      ES_PLANE: r = a[AW-1:AW-PW] == ers_addr_q[AW-1:AW-PW];
      default:  r = 1'b1;
    endcase
    return r;
  endfunction

  assign running = (st == ST_PRUN) | (st == ST_ERUN) | (st == ST_EPRUN);
  assign esusp   = (st == ST_ESUSP) | (st == ST_EPSETUP) | (st == ST_EPRUN);
  assign psusp   = (st == ST_PSUSP);

  always_comb begin
    st_n     = st;
    sel_n    = sel_q;
    iss      = 1'b0;
    icmd     = AC_NONE;
    ecap     = 1'b0;
    pcap     = 1'b0;
    set_lock = 1'b0;
    set_seq  = 1'b0;
    set_perr = 1'b0;
    set_eerr = 1'b0;
    clr      = 1'b0;
    if (wr_valid) begin
      unique case (st)
        ST_PSETUP, ST_EPSETUP: begin
          sel_n = RS_STATUS;
          if (lock_map[wr_addr[AW-1:SW]]) begin
            set_lock = 1'b1;
            st_n     = (st == ST_PSETUP) ? ST_IDLE : ST_ESUSP;
          end else if (st == ST_EPSETUP && in_held_erase(wr_addr)) begin
            set_perr = 1'b1;
            st_n     = ST_ESUSP;
          end else begin
            iss  = 1'b1;
            icmd = AC_PROG;
            pcap = 1'b1;
            st_n = (st == ST_PSETUP) ? ST_PRUN : ST_EPRUN;
          end
        end
        ST_ESETUP: begin
          sel_n = RS_STATUS;
          st_n  = ST_IDLE;
          if (!cf_ok) begin
            set_seq  = 1'b1;
            set_eerr = 1'b1;
          end else if (err_block) begin
            st_n = ST_IDLE;
          end else if (scope_locked(cf_scope, wr_addr, lock_map)) begin
            set_lock = 1'b1;
          end else begin
            iss  = 1'b1;
            ecap = 1'b1;
            st_n = ST_ERUN;
            unique case (cf_scope)
              ES_SECT:  icmd = AC_ERS_SECT;
              ES_PLANE: icmd = AC_ERS_PLANE;
              default:  icmd = AC_ERS_CHIP;
            endcase
          end
        end
        default: begin
          unique case (op)
            OP_RSTAT: sel_n = RS_STATUS;
            OP_RARR:  sel_n = RS_ARRAY;
            OP_RID:   sel_n = RS_IDENT;
            OP_CLR:   clr   = 1'b1;
            OP_PROG: begin
              if (st == ST_IDLE) begin
                st_n  = ST_PSETUP;
                sel_n = RS_STATUS;
              end else if (st == ST_ESUSP) begin
                st_n  = ST_EPSETUP;
                sel_n = RS_STATUS;
              end
            end
            OP_ERASE: begin
              if (st == ST_IDLE) begin
                st_n  = ST_ESETUP;
                sel_n = RS_STATUS;
              end
            end
            OP_SUSP: begin
              if (st == ST_PRUN || st == ST_ERUN) begin
                iss   = 1'b1;
                icmd  = AC_SUSP;
                sel_n = RS_STATUS;
                st_n  = (st == ST_PRUN) ? ST_PSUSP : ST_ESUSP;
              end
            end
            OP_RES: begin
              if (st == ST_PSUSP || st == ST_ESUSP) begin
                iss   = 1'b1;
                icmd  = AC_RES;
                sel_n = RS_STATUS;
                st_n  = (st == ST_PSUSP) ? ST_PRUN : ST_ERUN;
              end
            end
            default: st_n = st;
          endcase
        end
      endcase
    end
    // completion wins over a suspend arriving in the same cycle
    if (arr_done && running) begin
      if (arr_fail) begin
        if (st == ST_ERUN) set_eerr = 1'b1;
        else               set_perr = 1'b1;
      end
      st_n = (st == ST_EPRUN) ? ST_ESUSP : ST_IDLE;
      if (icmd == AC_SUSP) begin
        iss  = 1'b0;
        icmd = AC_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      sel_q       <= RS_ARRAY;
      ers_scope_q <= ES_SECT;
      ers_addr_q  <= '0;
      prg_addr_q  <= '0;
      arr_valid   <= 1'b0;
      arr_cmd     <= AC_NONE;
      arr_addr    <= '0;
      arr_data    <= '0;
    end else begin
      st        <= st_n;
      sel_q     <= sel_n;
      arr_valid <= iss;
      if (iss) begin
        arr_cmd  <= icmd;
        arr_addr <= wr_addr;
        arr_data <= (icmd == AC_PROG) ? wr_data : '0;
      end
      if (ecap) begin
        ers_scope_q <= cf_scope;
        ers_addr_q  <= wr_addr;
      end
      if (pcap) prg_addr_q <= wr_addr;
    end
  end

  assign rd_sel = sel_q;

  always_comb begin
    if (st == ST_ERUN) ers_mode = RG_ACTIVE;
    else if (esusp)    ers_mode = RG_HELD;
    else               ers_mode = RG_NONE;
    if (st == ST_PRUN || st == ST_EPRUN) prg_mode = RG_ACTIVE;
    else if (psusp)                      prg_mode = RG_HELD;
    else                                 prg_mode = RG_NONE;
  end

  fcsm_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_lock  (set_lock),
    .set_seq   (set_seq),
    .set_perr  (set_perr),
    .set_eerr  (set_eerr),
    .clr       (clr),
    .busy      (running),
    .esusp     (esusp),
    .psusp     (psusp),
    .status    (status),
    .err_block (err_block)
  );

  fcsm_readgate #(
    .AW(AW), .SW(SW), .PW(PW), .DW(DW), .MAKER_ID(MAKER_ID), .DEVICE_ID(DEVICE_ID)
  ) u_rg (
    .rd_sel    (sel_q),
    .rd_addr   (rd_addr),
    .status    (status),
    .ers_mode  (ers_mode),
    .ers_scope (ers_scope_q),
    .ers_addr  (ers_addr_q),
    .prg_mode  (prg_mode),
    .prg_addr  (prg_addr_q),
    .rd_allow  (rd_allow),
    .ctl_rdata (ctl_rdata)
  );

endmodule

// File: rtl/fcsm_chk.sv
module fcsm_chk #(
  parameter int AW = 10,
  parameter int SW = 6,
  parameter int DW = 16,
  localparam int NSECT = 1 << (AW - SW)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic [DW-1:0]    wr_data,
  input logic [NSECT-1:0] lock_map,
  input logic             arr_valid,
  input logic [2:0]       arr_cmd,
  input logic [AW-1:0]    arr_addr,
  input logic [1:0]       rd_sel,
  input logic [7:0]       status
);

  logic [NSECT-1:0] lock_d;
  always_ff @(posedge clk) lock_d <= lock_map;

  logic clr_wr;
  assign clr_wr = wr_valid && (wr_data[7:0] == 8'h50);

  a_r3_busy_on_program: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && arr_cmd == 3'd1) |-> !status[7]);

  a_r4_busy_on_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && arr_cmd >= 3'd2 && arr_cmd <= 3'd4) |-> !status[7]);

  a_r6_suspend_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && arr_cmd == 3'd5) |-> (status[7] && (status[6] || status[2])));

  a_r6_one_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({status[6], status[2]}));

  a_r9_no_locked_program: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && arr_cmd == 3'd1) |-> !lock_d[arr_addr[AW-1:SW]]);

  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !clr_wr) |=> status[1]);

  a_r10_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !clr_wr) |=> status[4]);

  a_r2_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel != 2'b11);

endmodule

bind flash_cmd_fsm fcsm_chk #(.AW(AW), .SW(SW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_data   (wr_data),
  .lock_map  (lock_map),
  .arr_valid (arr_valid),
  .arr_cmd   (arr_cmd),
  .arr_addr  (arr_addr),
  .rd_sel    (rd_sel),
  .status    (status)
);

// File: tb/sim_flash_cmd_fsm.sv
module sim_flash_cmd_fsm;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] lock_map = 16'h0002;
  logic        arr_done = 1'b0;
  logic        arr_fail = 1'b0;
  logic [9:0]  rd_addr = '0;
  logic        arr_valid;
  logic [2:0]  arr_cmd;
  logic [9:0]  arr_addr;
  logic [15:0] arr_data;
  logic [1:0]  rd_sel;
  logic [7:0]  status;
  logic        rd_allow;
  logic [15:0] ctl_rdata;

  int total = 0;
  int bad   = 0;
  logic finished = 1'b0;

  logic [2:0]  seen_cmd;
  logic [9:0]  seen_addr;
  logic [15:0] seen_data;

  always #5 clk = ~clk;

  flash_cmd_fsm u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .lock_map(lock_map), .arr_done(arr_done), .arr_fail(arr_fail), .rd_addr(rd_addr),
    .arr_valid(arr_valid), .arr_cmd(arr_cmd), .arr_addr(arr_addr), .arr_data(arr_data),
    .rd_sel(rd_sel), .status(status), .rd_allow(rd_allow), .ctl_rdata(ctl_rdata)
  );

  always @(posedge clk) begin
    if (arr_valid) begin
      seen_cmd  = arr_cmd;
      seen_addr = arr_addr;
      seen_data = arr_data;
    end
  end

  typedef struct packed {
    logic [1:0] kind;   // 0 write, 1 done ok, 2 done fail
    logic [9:0] addr;
    logic [7:0] data;
    logic [7:0] stat;
    logic [1:0] sel;
    logic [2:0] cmd;    // 0: no command issued in the step
    logic [3:0] req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 10'h000, 8'h90, 8'h80, 2'd2, 3'd0, 4'd2},   // R2 ident
    '{2'd0, 10'h000, 8'hFF, 8'h80, 2'd0, 3'd0, 4'd2},   // R2 array
    '{2'd0, 10'h000, 8'h70, 8'h80, 2'd1, 3'd0, 4'd2},   // R2 status
    '{2'd0, 10'h100, 8'h40, 8'h80, 2'd1, 3'd0, 4'd3},   // R3 setup
    '{2'd0, 10'h105, 8'h55, 8'h00, 2'd1, 3'd1, 4'd3},   // R3 start
    '{2'd1, 10'h000, 8'h00, 8'h80, 2'd1, 3'd0, 4'd3},   // R3 done
    '{2'd0, 10'h200, 8'h20, 8'h80, 2'd1, 3'd0, 4'd4},   // R4 setup
    '{2'd0, 10'h200, 8'hD0, 8'hA8, 2'd1, 3'd0, 4'd5},   // R5 bad confirm
    '{2'd0, 10'h200, 8'h20, 8'hA8, 2'd1, 3'd0, 4'd11},  // R11 setup
    '{2'd0, 10'h200, 8'h20, 8'hA8, 2'd1, 3'd0, 4'd11},  // R11 blocked
    '{2'd0, 10'h000, 8'h50, 8'h80, 2'd1, 3'd0, 4'd10},  // R10 clear
    '{2'd0, 10'h200, 8'h20, 8'h80, 2'd1, 3'd0, 4'd4},
    '{2'd0, 10'h200, 8'h20, 8'h00, 2'd1, 3'd2, 4'd4},   // R4 sector
    '{2'd0, 10'h000, 8'hB0, 8'hC0, 2'd1, 3'd5, 4'd6},   // R6 erase suspend
    '{2'd0, 10'h000, 8'h40, 8'hC0, 2'd1, 3'd0, 4'd7},
    '{2'd0, 10'h210, 8'h12, 8'hD0, 2'd1, 3'd0, 4'd7},   // R7 inside region
    '{2'd0, 10'h000, 8'h40, 8'hD0, 2'd1, 3'd0, 4'd7},
    '{2'd0, 10'h300, 8'h34, 8'h50, 2'd1, 3'd1, 4'd7},   // R7 outside region
    '{2'd1, 10'h000, 8'h00, 8'hD0, 2'd1, 3'd0, 4'd7},   // R7 back to suspend
    '{2'd0, 10'h000, 8'hD0, 8'h10, 2'd1, 3'd6, 4'd6},   // R6 resume
    '{2'd1, 10'h000, 8'h00, 8'h90, 2'd1, 3'd0, 4'd10},  // R10 held
    '{2'd0, 10'h000, 8'h50, 8'h80, 2'd1, 3'd0, 4'd10},
    '{2'd0, 10'h000, 8'h40, 8'h80, 2'd1, 3'd0, 4'd9},
    '{2'd0, 10'h050, 8'h11, 8'h82, 2'd1, 3'd0, 4'd9},   // R9 locked word
    '{2'd0, 10'h000, 8'h50, 8'h80, 2'd1, 3'd0, 4'd10},
    '{2'd0, 10'h000, 8'h20, 8'h80, 2'd1, 3'd0, 4'd9},
    '{2'd0, 10'h000, 8'h22, 8'h82, 2'd1, 3'd0, 4'd9},   // R9 locked plane
    '{2'd0, 10'h000, 8'h50, 8'h80, 2'd1, 3'd0, 4'd10},
    '{2'd0, 10'h300, 8'h20, 8'h80, 2'd1, 3'd0, 4'd4},
    '{2'd0, 10'h300, 8'h22, 8'h00, 2'd1, 3'd3, 4'd4},   // R4 plane
    '{2'd2, 10'h000, 8'h00, 8'hA0, 2'd1, 3'd0, 4'd10},  // R10 erase fail
    '{2'd0, 10'h000, 8'h50, 8'h80, 2'd1, 3'd0, 4'd10},
    '{2'd0, 10'h000, 8'h40, 8'h80, 2'd1, 3'd0, 4'd3},
    '{2'd0, 10'h3C0, 8'h77, 8'h00, 2'd1, 3'd1, 4'd3},
    '{2'd0, 10'h000, 8'hB0, 8'h84, 2'd1, 3'd5, 4'd6},   // R6 program suspend
    '{2'd0, 10'h000, 8'h20, 8'h84, 2'd1, 3'd0, 4'd12},  // R12 invalid here
    '{2'd0, 10'h000, 8'h90, 8'h84, 2'd2, 3'd0, 4'd2},
    '{2'd0, 10'h000, 8'h3C, 8'h84, 2'd2, 3'd0, 4'd12},  // R12 undefined
    '{2'd0, 10'h000, 8'hD0, 8'h00, 2'd1, 3'd6, 4'd6},
    '{2'd2, 10'h000, 8'h00, 8'h90, 2'd1, 3'd0, 4'd10},  // R10 program fail
    '{2'd0, 10'h000, 8'h50, 8'h80, 2'd1, 3'd0, 4'd10},
    '{2'd0, 10'h000, 8'h20, 8'h80, 2'd1, 3'd0, 4'd9},
    '{2'd0, 10'h3FF, 8'h21, 8'h82, 2'd1, 3'd0, 4'd9},   // R9 locked chip
    '{2'd0, 10'h000, 8'h50, 8'h80, 2'd1, 3'd0, 4'd10}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] kind, input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    seen_cmd = 3'd0;
    if (kind == 2'd0) begin
      wr_valid = 1'b1;
      wr_addr  = a;
      wr_data  = d;
    end else begin
      arr_done = 1'b1;
      arr_fail = (kind == 2'd2);
    end
    @(negedge clk);
    wr_valid = 1'b0;
    arr_done = 1'b0;
    arr_fail = 1'b0;
    @(negedge clk);
  endtask

  task automatic probe(input string tag, input logic [9:0] a, input logic exp);
    rd_addr = a;
    #1;
    chk(tag, 32'(rd_allow), 32'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", 32'(status), 32'h80);
    chk("R1 sel", 32'(rd_sel), 32'd0);
    chk("R1 valid", 32'(arr_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].kind, VECS[i].addr, {8'h00, VECS[i].data});
      chk($sformatf("R%0d v%0d status", VECS[i].req, i), 32'(status), 32'(VECS[i].stat));
      chk($sformatf("R%0d v%0d sel", VECS[i].req, i), 32'(rd_sel), 32'(VECS[i].sel));
      chk($sformatf("R%0d v%0d cmd", VECS[i].req, i), 32'(seen_cmd), 32'(VECS[i].cmd));
    end

    // R4 chip erase, R8 chip fence
    lock_map = 16'h0000;
    step(0, 10'h000, 16'h0020);
    step(0, 10'h123, 16'h0021);
    chk("R4 chip cmd", 32'(seen_cmd), 32'd4);
    step(0, 10'h000, 16'h00FF);
    probe("R8 chip busy", 10'h0C0, 1'b0);
    step(1, 10'h000, 16'h0000);
    probe("R8 chip done", 10'h0C0, 1'b1);

    // R4 confirm address, R8 sector erase fences
    step(0, 10'h000, 16'h0020);
    step(0, 10'h2C7, 16'h0020);
    chk("R4 erase addr", 32'(seen_addr), 32'h2C7);
    step(0, 10'h000, 16'h00FF);
    probe("R8 erase same sector", 10'h2C5, 1'b0);
    probe("R8 erase other plane", 10'h085, 1'b1);
    probe("R8 erase same plane", 10'h205, 1'b0);
    step(0, 10'h000, 16'h00B0);
    step(0, 10'h000, 16'h00FF);
    probe("R8 held erase sector", 10'h2C5, 1'b0);
    probe("R8 held erase neighbour", 10'h285, 1'b1);
    step(0, 10'h000, 16'h00D0);
    chk("R6 resume cmd", 32'(seen_cmd), 32'd6);
    step(1, 10'h000, 16'h0000);

    // R3 alternate setup code and full data word; R8 held program word
    step(0, 10'h000, 16'h0010);
    step(0, 10'h155, 16'hBE5A);
    chk("R3 program cmd", 32'(seen_cmd), 32'd1);
    chk("R3 program data", 32'(seen_data), 32'hBE5A);
    chk("R3 program addr", 32'(seen_addr), 32'h155);
    step(0, 10'h000, 16'h00B0);
    step(0, 10'h000, 16'h00FF);
    probe("R8 held program word", 10'h155, 1'b0);
    probe("R8 held program other", 10'h156, 1'b1);
    step(0, 10'h000, 16'h00D0);
    step(1, 10'h000, 16'h0000);

    // R2 identification and status data
    step(0, 10'h000, 16'h0090);
    rd_addr = 10'h200; #1;
    chk("R2 maker", 32'(ctl_rdata), 32'h00C3);
    rd_addr = 10'h201; #1;
    chk("R2 device", 32'(ctl_rdata), 32'h00E4);
    rd_addr = 10'h202; #1;
    chk("R2 other offset", 32'(ctl_rdata), 32'h0000);
    rd_addr = 10'h301; #1;
    chk("R2 device plane3", 32'(ctl_rdata), 32'h00E4);
    step(0, 10'h000, 16'h0070);
    chk("R2 status data", 32'(ctl_rdata), 32'h0080);

    // R1 reset during a running program
    step(0, 10'h000, 16'h0040);
    step(0, 10'h010, 16'h0001);
    chk("R1 running", 32'(status), 32'h00);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset status", 32'(status), 32'h80);
    chk("R1 reset sel", 32'(rd_sel), 32'd0);
    probe("R1 reset allow", 10'h010, 1'b1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule